// File: doc/BRIEF.md
# Two-Stage 16-bit Two-Address Processor Core

This block is a compact 16-bit processor core that runs a two-stage pipeline. In the first stage the program counter drives a synchronous instruction-memory port, and the word comes back one clock later. In the second stage that word is decoded and executed in the same cycle. The second stage works against a sixteen-entry register file, an arithmetic/logic unit, a set of condition flags and a synchronous data-memory port.

Every instruction is one 16-bit word. The top nibble picks the operation and the next nibble names the destination register, which is also the first operand. The low byte holds one of three things: a sign-extended immediate, a secondary operation code with a source register, or a branch displacement. A taken branch or jump discards the word that was fetched behind it. A load spends one extra cycle, because its data arrives from the synchronous memory port one cycle after the address is issued.

Top module: `pipe2_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the core sets `imem_addr` to 0 and drops the second-stage instruction, so `dmem_we` stays 0 in the cycle that follows reset.
- R2: With no redirect and no load, `imem_addr` rises by one every cycle. The word returned for an address is executed in the next cycle.
- R3: The instruction fields are op = bits [15:12], dest = [11:8] and low byte = [7:0]. For register and immediate operations, the destination register is both the first operand and the result register.
- R4: Op 0 is the register group, with ext = bits [7:4] and source = [3:0]. The ext values are: 0 ADD, 1 SUB, 2 AND, 3 OR, 4 XOR, 5 CMP (flags only, no write), 6 MOV.
- R5: The immediate ops are 1 ADDI, 2 SUBI, 3 MOVI and 4 CMPI. Each sign-extends its 8-bit immediate to 16 bits.
- R6: ADD, SUB, CMP, ADDI, SUBI and CMPI update the flags C, Z and N. C is the carry out for an add and the no-borrow bit for a subtract. Z means the result is zero, and N is bit 15 of the result. No other instruction changes the flags.
- R7: Op 6 is a conditional branch. Its condition is bits [11:8]: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 always, 7-15 never. The target is the branch's own address plus the sign-extended low byte.
- R8: A taken branch or jump puts its target on `imem_addr` in the next cycle. The word fetched behind it is discarded: it writes no register and raises no `dmem_we`.
- R9: Op 7 is a register jump to R[bits 3:0]. With ext 0 it is a plain jump. With ext 1 it also writes the jump's address plus one into the dest register.
- R10: Op 5 with ext 1 is a store. In the cycle the store executes, the core raises `dmem_we` and drives `dmem_addr` = R[bits 3:0] and `dmem_wdata` = R[dest].
- R11: Op 5 with ext 0 is a load. The core issues `dmem_addr` = R[bits 3:0] and holds `imem_addr` for one cycle. It writes the returned `dmem_rdata` into dest, and the very next instruction reads that new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 16 | Word address of the instruction being fetched |
| imem_rdata | input | 16 | Instruction word returned one cycle after its address |
| dmem_addr | output | 16 | Data-memory word address |
| dmem_wdata | output | 16 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 16 | Load data returned one cycle after its address |

## Verification
An instruction whose address is on `imem_addr` during cycle k executes in cycle k+1. Its store strobe and data address are therefore visible in that same cycle k+1. A redirect shows on `imem_addr` in cycle k+2, and a load holds `imem_addr` through cycle k+2. The bench samples at the falling edge and walks a short directed program one edge at a time, so that each of these offsets is checked at exactly the cycle where it is due. The longer program lets every store retire before the bench compares the data-memory image, so instruction results are judged only after they are complete.

// File: rtl/pipe2_pkg.sv
package pipe2_pkg;

    localparam int DW  = 16;
    localparam int RAW = 4;
    localparam int IMM_W = 8;

    typedef enum logic [3:0] {
        OP_RR   = 4'd0,
        OP_ADDI = 4'd1,
        OP_SUBI = 4'd2,
        OP_MOVI = 4'd3,
        OP_CMPI = 4'd4,
        OP_MEM  = 4'd5,
        OP_BCC  = 4'd6,
        OP_JUMP = 4'd7
    } major_e;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_AND,
        ALU_OR,
        ALU_XOR,
        ALU_PASS
    } alu_op_e;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
    } flags_t;

    typedef struct packed {
        logic           rf_we;
        logic           set_flags;
        logic           use_imm;
        alu_op_e        alu_op;
        logic           is_load;
        logic           is_store;
        logic           is_branch;
        logic           is_jump;
        logic           is_link;
        logic [3:0]     cond;
        logic [RAW-1:0] rd;
        logic [RAW-1:0] rs;
        logic [DW-1:0]  imm;
    } ctrl_t;

    typedef struct packed {
        logic [DW-1:0]  pc;
        logic [DW-1:0]  s2_pc;
        logic           s2_valid;
        logic           load_pend;
        logic [RAW-1:0] load_rd;
        flags_t         flags;
    } core_state_t;

    function automatic logic cond_met(input logic [3:0] cc, input flags_t f);
        case (cc)
            4'd0:    return f.z;
            4'd1:    return !f.z;
            4'd2:    return f.c;
            4'd3:    return !f.c;
            4'd4:    return f.n;
            4'd5:    return !f.n;
            4'd6:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pipe2_decode.sv
module pipe2_decode
    import pipe2_pkg::*;
(
    input  logic          valid,
    input  logic [DW-1:0] instr,
    output ctrl_t         ctrl
);

    logic [3:0] ext;
    major_e     major;

    assign ext   = instr[7:4];
    assign major = major_e'(instr[DW-1:DW-4]);

    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        if (valid) begin
            ctrl.rd   = instr[11:8];
            ctrl.rs   = instr[RAW-1:0];
            ctrl.cond = instr[11:8];
            ctrl.imm  = {{(DW-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
            case (major)
                OP_RR: begin
                    case (ext)
                        4'd0: begin ctrl.alu_op = ALU_ADD;  ctrl.rf_we = 1'b1; ctrl.set_flags = 1'b1; end
                        4'd1: begin ctrl.alu_op = ALU_SUB;  ctrl.rf_we = 1'b1; ctrl.set_flags = 1'b1; end
                        4'd2: begin ctrl.alu_op = ALU_AND;  ctrl.rf_we = 1'b1; end
                        4'd3: begin ctrl.alu_op = ALU_OR;   ctrl.rf_we = 1'b1; end
                        4'd4: begin ctrl.alu_op = ALU_XOR;  ctrl.rf_we = 1'b1; end
                        4'd5: begin ctrl.alu_op = ALU_SUB;  ctrl.set_flags = 1'b1; end
                        4'd6: begin ctrl.alu_op = ALU_PASS; ctrl.rf_we = 1'b1; end
                        default: ;
                    endcase
                end
                OP_ADDI: begin
                    ctrl.alu_op = ALU_ADD; ctrl.use_imm = 1'b1;
                    ctrl.rf_we = 1'b1; ctrl.set_flags = 1'b1;
                end
                OP_SUBI: begin
                    ctrl.alu_op = ALU_SUB; ctrl.use_imm = 1'b1;
                    ctrl.rf_we = 1'b1; ctrl.set_flags = 1'b1;
                end
                OP_MOVI: begin
                    ctrl.alu_op = ALU_PASS; ctrl.use_imm = 1'b1; ctrl.rf_we = 1'b1;
                end
                OP_CMPI: begin
                    ctrl.alu_op = ALU_SUB; ctrl.use_imm = 1'b1; ctrl.set_flags = 1'b1;
                end
                OP_MEM: begin
                    ctrl.is_load  = (ext == 4'd0);
                    ctrl.is_store = (ext == 4'd1);
                end
                OP_BCC: ctrl.is_branch = 1'b1;
                OP_JUMP: begin
                    ctrl.is_jump = (ext == 4'd0) || (ext == 4'd1);
                    ctrl.is_link = (ext == 4'd1);
                    ctrl.rf_we   = (ext == 4'd1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pipe2_alu.sv
module pipe2_alu
    import pipe2_pkg::*;
#(
    parameter int W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output flags_t       fl
);

    logic         sub;
    logic [W-1:0] b_eff;
    logic [W:0]   sum;

    assign sub   = (op == ALU_SUB);
    assign b_eff = sub ? ~b : b;
    assign sum   = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};

    always_comb begin
        case (op)
            ALU_ADD,
            ALU_SUB:  y = sum[W-1:0];
            ALU_AND:  y = a & b;
            ALU_OR:   y = a | b;
            ALU_XOR:  y = a ^ b;
            ALU_PASS: y = b;
            default:  y = '0;
        endcase
        fl.c = sum[W];
        fl.z = (y == '0);
        fl.n = y[W-1];
    end

endmodule

// File: rtl/pipe2_regfile.sv
module pipe2_regfile #(
    parameter int W     = 16,
    parameter int NREGS = 16,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs [NREGS];

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (we && (wa == AW'(i))) begin
                q <= wd;
            end
        end
        assign regs[i] = q;
    end

    assign ra_data = regs[ra_addr];
    assign rb_data = regs[rb_addr];

endmodule

// File: rtl/pipe2_cpu.sv
module pipe2_cpu
    import pipe2_pkg::*;
#(
    parameter int NREGS = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic [DW-1:0] imem_addr,
    input  logic [DW-1:0] imem_rdata,
    output logic [DW-1:0] dmem_addr,
    output logic [DW-1:0] dmem_wdata,
    output logic          dmem_we,
    input  logic [DW-1:0] dmem_rdata
);

    core_state_t    st_q, st_d;
    ctrl_t          ctrl;
    logic [DW-1:0]  ra_data, rb_data, alu_b, alu_y, target;
    flags_t         alu_fl;
    logic           s2_valid, load_pend, redirect, stall;
    logic           rf_we;
    logic [RAW-1:0] rf_wa;
    logic [DW-1:0]  rf_wd;

    assign s2_valid  = st_q.s2_valid;
    assign load_pend = st_q.load_pend;

    pipe2_decode u_dec (
        .valid (s2_valid),
        .instr (imem_rdata),
        .ctrl  (ctrl)
    );

    pipe2_regfile #(.W(DW), .NREGS(NREGS)) u_rf (
        .clk     (clk),
        .ra_addr (ctrl.rd),
        .ra_data (ra_data),
        .rb_addr (ctrl.rs),
        .rb_data (rb_data),
        .we      (rf_we),
        .wa      (rf_wa),
        .wd      (rf_wd)
    );

    assign alu_b = ctrl.use_imm ? ctrl.imm : rb_data;

    pipe2_alu #(.W(DW)) u_alu (
        .op (ctrl.alu_op),
        .a  (ra_data),
        .b  (alu_b),
        .y  (alu_y),
        .fl (alu_fl)
    );

    // control transfer and load stall
    always_comb begin
        redirect = ctrl.is_jump || (ctrl.is_branch && cond_met(ctrl.cond, st_q.flags));
        target   = ctrl.is_branch ? (st_q.s2_pc + ctrl.imm) : rb_data;
        stall    = ctrl.is_load;
    end

    // register write: execute result, or load return one cycle later
    always_comb begin
        if (st_q.load_pend) begin
            rf_we = 1'b1;
            rf_wa = st_q.load_rd;
            rf_wd = dmem_rdata;
        end else begin
            rf_we = ctrl.rf_we;
            rf_wa = ctrl.rd;
            rf_wd = ctrl.is_link ? (st_q.s2_pc + DW'(1)) : alu_y;
        end
    end

    // next-state
    always_comb begin
        st_d           = st_q;
        st_d.pc        = st_q.pc + DW'(1);
        st_d.s2_pc     = st_q.pc;
        st_d.s2_valid  = 1'b1;
        st_d.load_pend = stall;
        st_d.load_rd   = ctrl.rd;
        if (ctrl.set_flags) begin
            st_d.flags = alu_fl;
        end
        if (redirect) begin
            st_d.pc       = target;
            st_d.s2_valid = 1'b0;
        end else if (stall) begin
            st_d.pc       = st_q.pc;
            st_d.s2_valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign imem_addr  = st_q.pc;
    assign dmem_addr  = rb_data;
    assign dmem_wdata = ra_data;
    assign dmem_we    = ctrl.is_store;

endmodule

// File: rtl/pipe2_cpu_chk.sv
module pipe2_cpu_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] imem_addr,
    input logic        dmem_we,
    input logic        s2_valid,
    input logic        redirect,
    input logic        stall,
    input logic        load_pend
);

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (imem_addr == 16'd0) && !dmem_we && !s2_valid);

    assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (rst)
        (!redirect && !stall) |=> (imem_addr == 16'($past(imem_addr) + 16'd1)));

    assert_squash_R8: assert property (@(posedge clk) disable iff (rst)
        redirect |=> (!s2_valid && !dmem_we));

    assert_load_hold_R11: assert property (@(posedge clk) disable iff (rst)
        stall |=> ((imem_addr == $past(imem_addr)) && load_pend));

    assert_pend_nostore_R10: assert property (@(posedge clk) disable iff (rst)
        load_pend |-> !dmem_we);

endmodule

bind pipe2_cpu pipe2_cpu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .s2_valid  (s2_valid),
    .redirect  (redirect),
    .stall     (stall),
    .load_pend (load_pend)
);

// File: tb/pipe2_cpu_bench.sv
`timescale 1ns/1ps
module pipe2_cpu_bench;

    localparam logic [15:0] PROG [64] = '{
        16'h3105, 16'h32FD, 16'h3320, 16'h3A32, 16'h0102, 16'h6202, 16'h511A, 16'h5113,
        16'h1301, 16'h340F, 16'h0562, 16'h0524, 16'h5513, 16'h1301, 16'h0531, 16'h0542,
        16'h5513, 16'h1301, 16'h2502, 16'h0514, 16'h5513, 16'h1301, 16'h3720, 16'h5607,
        16'h0606, 16'h5613, 16'h1301, 16'h4604, 16'h6003, 16'h511A, 16'h511A, 16'h0651,
        16'h6102, 16'h511A, 16'h6002, 16'h397E, 16'h4103, 16'h6302, 16'h511A, 16'h6402,
        16'h511A, 16'h6502, 16'h6702, 16'h5913, 16'h1301, 16'h3B31, 16'h7C1B, 16'h511A,
        16'h511A, 16'h5C13, 16'h3DFF, 16'h1D01, 16'h6002, 16'h511A, 16'h1301, 16'h0D61,
        16'h1D80, 16'h5D13, 16'h1301, 16'h3E3E, 16'h700E, 16'h511A, 16'h5E13, 16'h6600
    };

    localparam int NEXP = 10;
    localparam logic [5:0]  EXP_A [NEXP] = '{6'd32, 6'd33, 6'd34, 6'd35, 6'd36,
                                             6'd37, 6'd38, 6'd39, 6'd40, 6'd50};
    localparam logic [15:0] EXP_D [NEXP] = '{16'h0002, 16'h000D, 16'hFFF2, 16'hFFE1, 16'h0004,
                                             16'h007E, 16'h002F, 16'hFF82, 16'h003E, 16'h1232};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [15:0] imem [64];
    logic [15:0] dmem [64];
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    pipe2_cpu u_pipe2_cpu (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    // synchronous memory models; data memory preset to 0x1200+index in reset
    always @(posedge clk) begin
        imem_rdata <= imem[imem_addr[5:0]];
        if (rst) begin
            for (int i = 0; i < 64; i++) dmem[i] <= 16'h1200 + 16'(i);
            dmem_rdata <= 16'h0;
        end else begin
            if (dmem_we) dmem[dmem_addr[5:0]] <= dmem_wdata;
            dmem_rdata <= dmem[dmem_addr[5:0]];
        end
    end

    function automatic string exp_tag(input int i);
        case (i)
            0: return "R4 add/carry";
            1: return "R3 two-address mov/and";
            2: return "R4 or/xor";
            3: return "R5 subi/sub";
            4: return "R11 load-use";
            5: return "R6 flags/conditions";
            6: return "R9 link value";
            7: return "R5 negative immediate";
            8: return "R9 register jump";
            default: return "R8 squashed stores";
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL R2 watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) imem[i] = PROG[i];
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset fetch address", imem_addr, 16'h0000);
        check("R1 reset store strobe", {15'h0, dmem_we}, 16'h0000);
        rst = 1'b0;
        repeat (150) @(negedge clk);

        // walk the expected data-memory image
        for (int i = 0; i < NEXP; i++) begin
            check(exp_tag(i), dmem[EXP_A[i]], EXP_D[i]);
        end

        // directed timing program
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 64; i++) imem[i] = 16'h6600;
        imem[0] = 16'h3008;   // MOVI r0, 8
        imem[1] = 16'h6604;   // branch always +4 -> 5
        imem[2] = 16'h5110;   // store (must be squashed)
        imem[5] = 16'h5100;   // LOAD r1, [r0]
        imem[6] = 16'h5110;   // STOR r1 -> [r0]
        imem[7] = 16'h6600;   // self loop
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 fetch address after reset", imem_addr, 16'd0);
        check("R1 no store after reset", {15'h0, dmem_we}, 16'h0000);
        @(negedge clk);
        check("R2 sequential fetch", imem_addr, 16'd1);
        @(negedge clk);
        check("R2 sequential fetch", imem_addr, 16'd2);
        @(negedge clk);
        check("R7 branch target on fetch port", imem_addr, 16'd5);
        check("R8 squashed store strobe", {15'h0, dmem_we}, 16'h0000);
        @(negedge clk);
        check("R11 load address", dmem_addr, 16'd8);
        check("R11 load no strobe", {15'h0, dmem_we}, 16'h0000);
        @(negedge clk);
        check("R11 fetch held during load", imem_addr, 16'd6);
        @(negedge clk);
        check("R2 fetch resumes after load", imem_addr, 16'd7);
        check("R10 store strobe", {15'h0, dmem_we}, 16'h0001);
        check("R10 store address", dmem_addr, 16'd8);
        check("R11 loaded value forwarded to store", dmem_wdata, 16'h1208);
        @(negedge clk);
        @(negedge clk);
        check("R8 self-branch redirect", imem_addr, 16'd7);

        summary();
        $finish;
    end

endmodule